// File: doc/BRIEF.md
# Serial Multiprocessor Address Filter

This block sits next to a 9-bit asynchronous serial receiver. For each received frame it decides whether the frame reaches software. In multiprocessor operation the receiver's ninth bit marks address frames. An address frame is accepted only when the received byte matches the node's own address under a per-bit compare mask, or when it covers the node's broadcast pattern. Data frames, whose ninth bit is 0, are dropped until software has cleared the multiprocessor enable after being addressed. A frame that is not accepted leaves the receive flag and the data output alone.

The receiver gives two strobes per frame. `data_strobe` comes when the last data bit is in, with the byte and the ninth bit. `stop_strobe` comes when the stop bit is sampled, with its value. When framing-error detection is off, a frame is committed on `data_strobe`. When it is on, the frame is captured at `data_strobe` and committed at `stop_strobe`. A zero stop bit then sets a sticky error flag. Software writes the node address, the compare mask, and a status word that clears the flags.

Top module: `uart_mpa_filter`

## Requirements
- R1: After reset, `rx_done`, `frame_err`, `addr_hit`, `rx_data` and `rx_data_ninth` are 0. The own address and the compare mask are 00h, so every address frame matches the own address.
- R2: An address frame matches the own address when every received bit whose mask bit is 1 equals the own-address bit. Bits whose mask bit is 0 are ignored.
- R3: An address frame also matches when it has a 1 in every bit position where (own address OR mask) is 1.
- R4: With `nine_bit_mode`=1 and `mp_enable`=1, a frame with ninth bit 1 that matches neither R2 nor R3 is rejected. `rx_done`, `rx_data`, `rx_data_ninth` and `addr_hit` keep their values.
- R5: With `nine_bit_mode`=1 and `mp_enable`=1, a frame with ninth bit 0 is rejected. With `mp_enable`=0, or with `nine_bit_mode`=0, every frame is accepted.
- R6: With `fe_detect_en`=0, an accepted frame sets `rx_done` and loads `rx_data`/`rx_data_ninth` on the clock edge that samples `data_strobe`.
- R7: With `fe_detect_en`=1, `data_strobe` changes no output. The frame captured at `data_strobe` is judged and committed on the edge that samples the next `stop_strobe`.
- R8: With `fe_detect_en`=1, a `stop_strobe` with `rx_stop`=0 sets `frame_err`. This happens whether or not the frame is accepted. The flag stays set through later frames with a good stop bit. With `fe_detect_en`=0, it is never set.
- R9: A write with `wr_sel`=2 clears `rx_done` if `wr_data[0]`=1 and clears `frame_err` if `wr_data[1]`=1. A set in the same cycle wins over the clear.
- R10: `addr_hit` is loaded with each accepted frame. It is 1 when the frame passed the address check of R4, and 0 for every other accepted frame.
- R11: A write with `wr_sel`=0 loads the own address and a write with `wr_sel`=1 loads the mask. Both apply from the next cycle. A write with `wr_sel`=3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 own address, 1 mask, 2 status clear, 3 none |
| wr_data | input | 8 | Write data |
| nine_bit_mode | input | 1 | Receiver runs 9-bit frames |
| mp_enable | input | 1 | Multiprocessor address filtering enabled |
| fe_detect_en | input | 1 | Framing-error detection; commit moves to the stop bit |
| data_strobe | input | 1 | Last data bit received, byte and ninth bit valid |
| rx_byte | input | 8 | Received byte |
| rx_ninth | input | 1 | Received ninth bit |
| stop_strobe | input | 1 | Stop bit sampled |
| rx_stop | input | 1 | Sampled stop bit value |
| rx_done | output | 1 | Receive-complete flag |
| frame_err | output | 1 | Sticky framing-error flag |
| addr_hit | output | 1 | Last accepted frame passed the address check |
| rx_data | output | 8 | Last accepted byte |
| rx_data_ninth | output | 1 | Ninth bit of the last accepted frame |

## Verification
A software clear can land in the same cycle as a hardware set. One case is a status write that clears `rx_done` while an accepted frame commits. The other is a clear of `frame_err` while a stop bit of 0 is sampled. The bench drives both writes in exactly the strobe cycle. In each case it expects the flag to read 1 on the following cycle. A second collision is a mask or address write in the same cycle as `data_strobe`, and it must be judged against the old register values. A per-cycle reference model compares every output on every clock.

// File: rtl/uart_mpa_pkg.sv
// Shared definitions for the multiprocessor address filter.
package uart_mpa_pkg;
    localparam int BYTE_W = 8;
    localparam int SEL_W  = 2;

    // Targets of a software write.
    typedef enum logic [SEL_W-1:0] {
        SEL_ADDR   = 2'd0,
        SEL_MASK   = 2'd1,
        SEL_STATUS = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    // Bit positions inside a status write.
    localparam int CLR_DONE_BIT = 0;
    localparam int CLR_ERR_BIT  = 1;

    // One frame as judged at capture time.
    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              ninth;
        logic              accept;
        logic              hit;
    } frame_t;
endpackage

// File: rtl/uart_mpa_regs.sv
// Own-address and compare-mask registers plus decode of status clears.
// Assumes wr_sel values follow uart_mpa_pkg::reg_sel_e; reset values are 0.
module uart_mpa_regs
    import uart_mpa_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [W-1:0]     wr_data,
    output logic [W-1:0]     own_addr,
    output logic [W-1:0]     addr_mask,
    output logic             clr_done,
    output logic             clr_err
);
    // Load address or mask on a matching write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_addr  <= '0;
            addr_mask <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_ADDR) own_addr  <= wr_data;
            if (wr_sel == SEL_MASK) addr_mask <= wr_data;
        end
    end

    // Decode the clear requests carried by a status write.
    always_comb begin
        clr_done = wr_en && (wr_sel == SEL_STATUS) && wr_data[CLR_DONE_BIT];
        clr_err  = wr_en && (wr_sel == SEL_STATUS) && wr_data[CLR_ERR_BIT];
    end
endmodule

// File: rtl/uart_mpa_match.sv
// Combinational frame judge: own-address match under mask, broadcast match,
// and the acceptance rule for multiprocessor operation.
// Assumes inputs are valid in the cycle data_strobe is high.
module uart_mpa_match
    import uart_mpa_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic [W-1:0] own_addr,
    input  logic [W-1:0] addr_mask,
    input  logic [W-1:0] rx_byte,
    input  logic         rx_ninth,
    input  logic         nine_bit_mode,
    input  logic         mp_enable,
    output logic         accept,
    output logic         hit
);
    logic [W-1:0] given_miss;
    logic [W-1:0] bcast_miss;

    // Per-bit miss terms for both compare kinds.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign given_miss[i] = addr_mask[i] & (rx_byte[i] ^ own_addr[i]);
        assign bcast_miss[i] = (own_addr[i] | addr_mask[i]) & ~rx_byte[i];
    end

    // Acceptance: filtering only in 9-bit multiprocessor operation.
    always_comb begin
        logic filtering;
        logic addr_ok;
        filtering = nine_bit_mode && mp_enable;
        addr_ok   = (given_miss == '0) || (bcast_miss == '0);
        hit       = filtering && rx_ninth && addr_ok;
        accept    = !filtering || hit;
    end
endmodule

// File: rtl/uart_mpa_commit.sv
// Frame capture and commit: holds a frame between data and stop strobes when
// framing-error detection is on, and owns the flags and the data output.
// Assumes data_strobe and stop_strobe of one frame fall in different cycles.
module uart_mpa_commit
    import uart_mpa_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  frame_t       live,
    input  logic         fe_detect_en,
    input  logic         data_strobe,
    input  logic         stop_strobe,
    input  logic         rx_stop,
    input  logic         clr_done,
    input  logic         clr_err,
    output logic         rx_done,
    output logic         frame_err,
    output logic         addr_hit,
    output logic [W-1:0] rx_data,
    output logic         rx_data_ninth
);
    frame_t pend;
    logic   pend_valid;
    frame_t src;
    logic   commit;
    logic   bad_stop;

    // Choose when and from where a frame is committed.
    always_comb begin
        src      = fe_detect_en ? pend : live;
        commit   = fe_detect_en ? (stop_strobe && pend_valid) : data_strobe;
        bad_stop = fe_detect_en && stop_strobe && !rx_stop;
    end

    // Hold the judged frame until its stop bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend       <= '0;
            pend_valid <= 1'b0;
        end else if (data_strobe) begin
            pend       <= live;
            pend_valid <= 1'b1;
        end else if (stop_strobe) begin
            pend_valid <= 1'b0;
        end
    end

    // Receive flag and data output; a set wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_done       <= 1'b0;
            addr_hit      <= 1'b0;
            rx_data       <= '0;
            rx_data_ninth <= 1'b0;
        end else if (commit && src.accept) begin
            rx_done       <= 1'b1;
            addr_hit      <= src.hit;
            rx_data       <= src.data;
            rx_data_ninth <= src.ninth;
        end else if (clr_done) begin
            rx_done       <= 1'b0;
        end
    end

    // Sticky framing error; only software clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)        frame_err <= 1'b0;
        else if (bad_stop) frame_err <= 1'b1;
        else if (clr_err)  frame_err <= 1'b0;
    end

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_err && !clr_err) |=> frame_err);
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fe_detect_en && stop_strobe && !rx_stop) |=> frame_err);
    assert_no_early_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_done && fe_detect_en && !stop_strobe) |=> !rx_done);
    assert_no_fe_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_err && !fe_detect_en) |=> !frame_err);
endmodule

// File: rtl/uart_mpa_filter.sv
// Top of the multiprocessor address filter: register file, frame judge and
// commit stage. Assumes strobes come from a 9-bit receiver, one per cycle.
module uart_mpa_filter
    import uart_mpa_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [W-1:0]     wr_data,
    input  logic             nine_bit_mode,
    input  logic             mp_enable,
    input  logic             fe_detect_en,
    input  logic             data_strobe,
    input  logic [W-1:0]     rx_byte,
    input  logic             rx_ninth,
    input  logic             stop_strobe,
    input  logic             rx_stop,
    output logic             rx_done,
    output logic             frame_err,
    output logic             addr_hit,
    output logic [W-1:0]     rx_data,
    output logic             rx_data_ninth
);
    logic [W-1:0] own_addr;
    logic [W-1:0] addr_mask;
    logic         clr_done;
    logic         clr_err;
    logic         accept;
    logic         hit;
    frame_t       live;

    uart_mpa_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .own_addr(own_addr), .addr_mask(addr_mask),
        .clr_done(clr_done), .clr_err(clr_err)
    );

    uart_mpa_match #(.W(W)) u_match (
        .own_addr(own_addr), .addr_mask(addr_mask), .rx_byte(rx_byte),
        .rx_ninth(rx_ninth), .nine_bit_mode(nine_bit_mode),
        .mp_enable(mp_enable), .accept(accept), .hit(hit)
    );

    // Bundle the judged frame for the commit stage.
    always_comb begin
        live.data   = rx_byte;
        live.ninth  = rx_ninth;
        live.accept = accept;
        live.hit    = hit;
    end

    uart_mpa_commit #(.W(W)) u_commit (
        .clk(clk), .rst_n(rst_n), .live(live), .fe_detect_en(fe_detect_en),
        .data_strobe(data_strobe), .stop_strobe(stop_strobe), .rx_stop(rx_stop),
        .clr_done(clr_done), .clr_err(clr_err), .rx_done(rx_done),
        .frame_err(frame_err), .addr_hit(addr_hit), .rx_data(rx_data),
        .rx_data_ninth(rx_data_ninth)
    );

    assert_reject_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_strobe && !fe_detect_en && nine_bit_mode && mp_enable && !rx_ninth)
        |=> $stable(rx_data));
    assert_open_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (data_strobe && !fe_detect_en && !mp_enable) |=> (rx_done && !addr_hit));
    assert_hit_ninth_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_hit && $changed(rx_data)) |-> rx_data_ninth);
endmodule

// File: tb/uart_mpa_filter_bench.sv
module uart_mpa_filter_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd3;
    logic [7:0] wr_data = 8'd0;
    logic       nine_bit_mode = 1'b1;
    logic       mp_enable = 1'b1;
    logic       fe_detect_en = 1'b0;
    logic       data_strobe = 1'b0;
    logic [7:0] rx_byte = 8'd0;
    logic       rx_ninth = 1'b0;
    logic       stop_strobe = 1'b0;
    logic       rx_stop = 1'b1;
    logic       rx_done, frame_err, addr_hit, rx_data_ninth;
    logic [7:0] rx_data;

    int checks = 0;
    int fails = 0;
    string cur_req = "R1";
    bit comparing = 1'b0;

    // Reference model state
    int m_addr, m_mask, m_done, m_err, m_hit, m_data, m_ninth;
    int p_valid, p_data, p_ninth, p_acc, p_hit;

    always #5 clk = ~clk;

    uart_mpa_filter u_uart_mpa_filter (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .nine_bit_mode(nine_bit_mode), .mp_enable(mp_enable),
        .fe_detect_en(fe_detect_en), .data_strobe(data_strobe), .rx_byte(rx_byte),
        .rx_ninth(rx_ninth), .stop_strobe(stop_strobe), .rx_stop(rx_stop),
        .rx_done(rx_done), .frame_err(frame_err), .addr_hit(addr_hit),
        .rx_data(rx_data), .rx_data_ninth(rx_data_ninth)
    );

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Behavioural judge: walk the bits one by one.
    function automatic void judge(int b, int n, output int acc, output int hit);
        int own_ok = 1;
        int bc_ok = 1;
        for (int i = 0; i < 8; i++) begin
            if (m_mask[i] && (b[i] != m_addr[i])) own_ok = 0;
            if ((m_addr[i] || m_mask[i]) && !b[i]) bc_ok = 0;
        end
        if (nine_bit_mode && mp_enable) begin
            hit = (n == 1 && (own_ok || bc_ok)) ? 1 : 0;
            acc = hit;
        end else begin
            hit = 0;
            acc = 1;
        end
    endfunction

    // Reference model, stepped on each clock edge.
    always @(posedge clk) begin
        int acc, hit, c_acc, c_hit, c_data, c_ninth, do_commit;
        if (!rst_n) begin
            m_addr = 0; m_mask = 0; m_done = 0; m_err = 0; m_hit = 0;
            m_data = 0; m_ninth = 0; p_valid = 0; p_data = 0; p_ninth = 0;
            p_acc = 0; p_hit = 0;
        end else begin
            judge(rx_byte, rx_ninth, acc, hit);
            do_commit = 0;
            if (!fe_detect_en && data_strobe) begin
                do_commit = 1; c_acc = acc; c_hit = hit; c_data = rx_byte; c_ninth = rx_ninth;
            end else if (fe_detect_en && stop_strobe && p_valid == 1) begin
                do_commit = 1; c_acc = p_acc; c_hit = p_hit; c_data = p_data; c_ninth = p_ninth;
            end
            if (do_commit == 1 && c_acc == 1) begin
                m_done = 1; m_hit = c_hit; m_data = c_data; m_ninth = c_ninth;
            end else if (wr_en && wr_sel == 2 && wr_data[0]) m_done = 0;
            if (fe_detect_en && stop_strobe && !rx_stop) m_err = 1;
            else if (wr_en && wr_sel == 2 && wr_data[1]) m_err = 0;
            if (data_strobe) begin
                p_valid = 1; p_acc = acc; p_hit = hit; p_data = rx_byte; p_ninth = rx_ninth;
            end else if (stop_strobe) p_valid = 0;
            if (wr_en && wr_sel == 0) m_addr = wr_data;
            if (wr_en && wr_sel == 1) m_mask = wr_data;
        end
    end

    // Compare every output on each falling edge.
    always @(negedge clk) begin
        if (comparing) begin
            check(cur_req, "rx_done", rx_done, m_done);
            check(cur_req, "frame_err", frame_err, m_err);
            check(cur_req, "addr_hit", addr_hit, m_hit);
            check(cur_req, "rx_data", rx_data, m_data);
            check(cur_req, "rx_data_ninth", rx_data_ninth, m_ninth);
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_reg(int sel, int val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel[1:0]; wr_data = val[7:0];
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'd3;
    endtask

    task automatic frame(int b, int n, int stop);
        @(negedge clk);
        data_strobe = 1'b1; rx_byte = b[7:0]; rx_ninth = n[0];
        @(negedge clk);
        data_strobe = 1'b0; rx_byte = 8'h00; rx_ninth = 1'b0;
        idle(2);
        stop_strobe = 1'b1; rx_stop = stop[0];
        @(negedge clk);
        stop_strobe = 1'b0; rx_stop = 1'b1;
        idle(1);
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        check("R1", "reset rx_done", rx_done, 0);
        check("R1", "reset frame_err", frame_err, 0);
        check("R1", "reset rx_data", rx_data, 0);
        comparing = 1'b1;
        cur_req = "R1"; frame(8'h3C, 1, 1);
        check("R1", "open mask hit", addr_hit, 1);
        cur_req = "R11"; write_reg(0, 8'hA5); write_reg(1, 8'hF0); write_reg(2, 1);
        write_reg(3, 8'hFF);
        cur_req = "R2"; frame(8'hA3, 1, 1);
        check("R2", "masked own match data", rx_data, 8'hA3);
        write_reg(2, 1);
        cur_req = "R4"; frame(8'hB5, 1, 1);
        check("R4", "reject keeps done low", rx_done, 0);
        check("R4", "reject keeps data", rx_data, 8'hA3);
        cur_req = "R3"; frame(8'hF5, 1, 1);
        check("R3", "broadcast accept", rx_done, 1);
        frame(8'hFF, 1, 1);
        cur_req = "R5"; write_reg(2, 1); frame(8'h11, 0, 1);
        check("R5", "data frame rejected", rx_done, 0);
        mp_enable = 1'b0; frame(8'h22, 0, 1);
        check("R10", "open frame hit clear", addr_hit, 0);
        mp_enable = 1'b1; nine_bit_mode = 1'b0; frame(8'h33, 0, 1);
        check("R5", "8-bit mode accepts", rx_data, 8'h33);
        nine_bit_mode = 1'b1;
        cur_req = "R7"; write_reg(2, 1); fe_detect_en = 1'b1;
        @(negedge clk); data_strobe = 1'b1; rx_byte = 8'hF7; rx_ninth = 1'b1;
        @(negedge clk); data_strobe = 1'b0;
        check("R7", "no flag before stop", rx_done, 0);
        idle(1); stop_strobe = 1'b1; rx_stop = 1'b1;
        @(negedge clk); stop_strobe = 1'b0;
        check("R7", "flag at stop", rx_done, 1);
        cur_req = "R8"; frame(8'hA0, 1, 0);
        check("R8", "bad stop sets err", frame_err, 1);
        frame(8'hA1, 1, 1);
        check("R8", "err sticky", frame_err, 1);
        cur_req = "R9"; write_reg(2, 2);
        check("R9", "err cleared", frame_err, 0);
        // Clear and bad stop in the same cycle: set wins.
        @(negedge clk); data_strobe = 1'b1; rx_byte = 8'hAA; rx_ninth = 1'b1;
        @(negedge clk); data_strobe = 1'b0;
        stop_strobe = 1'b1; rx_stop = 1'b0; wr_en = 1'b1; wr_sel = 2'd2; wr_data = 8'h03;
        @(negedge clk); stop_strobe = 1'b0; rx_stop = 1'b1; wr_en = 1'b0; wr_sel = 2'd3;
        check("R9", "err set wins", frame_err, 1);
        check("R9", "done set wins", rx_done, 1);
        fe_detect_en = 1'b0; write_reg(2, 3);
        cur_req = "R6";
        @(negedge clk); data_strobe = 1'b1; rx_byte = 8'hF5; rx_ninth = 1'b1;
        wr_en = 1'b1; wr_sel = 2'd1; wr_data = 8'hFF;
        @(negedge clk); data_strobe = 1'b0; wr_en = 1'b0; wr_sel = 2'd3;
        check("R6", "commit on data strobe, old mask", rx_done, 1);
        cur_req = "R8"; frame(8'hFF, 1, 0);
        check("R8", "no err when detection off", frame_err, 0);
        cur_req = "R11"; write_reg(2, 1); frame(8'hF5, 1, 1);
        check("R11", "new mask rejects", rx_done, 0);
        frame(8'hA5, 1, 1);
        check("R11", "new mask exact match", rx_done, 1);
        idle(2);
        comparing = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule